// File: doc/BRIEF.md
# Latched Motor-Stall Protection Timer

This block guards a brushless motor drive against a stalled rotor. It watches a flag that the speed loop raises while the motor runs outside its lock window. If that flag stays raised for a programmable number of slow timebase ticks without a break, the block raises a trip signal. The commutation logic uses this trip to force every high-side drive output off.

Once raised, the trip is latched. It does not clear when the speed comes back into the lock window. Only a stop command, a disable strap or a power-on reset clears it. A stop also reloads the hold count, and timing starts again from the full hold time on the next run.

A strap input disables the whole function. It stands in for grounding the timing capacitor. Asynchronous resets are released through an internal synchronizer.

Top module: `stall_guard`

## Requirements
- R1: After reset `trip_o` is low and the hold count is full, so a full `HOLD_TICKS` unlocked ticks are needed before any trip.
- R2: While running (stop low, strap low, armed), `unlock_i` high for `HOLD_TICKS` consecutive cycles with `tick_i` high raises `trip_o` in the cycle after the last such tick cycle. Fewer ticks leave it low.
- R3: `unlock_i` low in any cycle before expiry reloads the count, so a full `HOLD_TICKS` further unlocked ticks are needed.
- R4: Once high, `trip_o` stays high while stop and strap stay low, whatever `unlock_i` and `tick_i` do.
- R5: `stop_i` high drives `trip_o` low from the next cycle and holds it low. Ticks seen while stopped are not counted.
- R6: When the block goes from stopped to running, the first running cycle only arms it. A tick in that cycle is not counted, and counting starts afresh from the full hold time.
- R7: `guard_off_i` high clears `trip_o` from the next cycle and suppresses all counting while it stays high.
- R8: Ticks with `unlock_i` low are never counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse of the slow hold timebase |
| unlock_i | input | 1 | High while motor speed is outside the lock window |
| stop_i | input | 1 | High = motor stopped; clears the latched trip |
| guard_off_i | input | 1 | Strap: high disables stall protection entirely |
| trip_o | output | 1 | Latched stall fault; high forces all high-side outputs off |

## Verification
The assertions check the following on every cycle:
- A rising trip always follows an unlocked tick cycle.
- Stop and the strap clear the trip one cycle later.
- A trip holds while both stop and strap are low.
- The hold count stays inside its range, reloads to full when loaded and steps down by one on each counted tick.

The bench scenarios check what needs history longer than one cycle: the exact tick on which the trip fires, the restart after a brief return to lock, that a tick in the arming cycle is ignored, and that locked ticks are not counted.

// File: rtl/stall_pkg.sv
package stall_pkg;

  // Guard states: idle (stopped or disabled), watching, tripped
  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_WATCH = 2'd1,
    GS_TRIP  = 2'd2
  } guard_state_e;

endpackage

// File: rtl/stall_rst_sync.sv
module stall_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rst_n_sync = pipe_q[STAGES-1];

endmodule

// File: rtl/stall_hold_cnt.sv
module stall_hold_cnt #(
  parameter int HOLD_TICKS = 158,
  parameter int CNT_W      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic dec_i,
  output logic last_o
);

  localparam logic [CNT_W-1:0] HOLD_VAL = CNT_W'(HOLD_TICKS);
  localparam logic [CNT_W-1:0] ONE_VAL  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | dec_i;
    if (load_i) begin
      cnt_d = HOLD_VAL;
    end else begin
      cnt_d = cnt_q - ONE_VAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= HOLD_VAL;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = (cnt_q == ONE_VAL);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= ONE_VAL) && (cnt_q <= HOLD_VAL)); // R1
  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == HOLD_VAL)); // R3
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i) |=> (cnt_q == $past(cnt_q) - ONE_VAL)); // R2

endmodule

// File: rtl/stall_guard_fsm.sv
module stall_guard_fsm
  import stall_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic unlock_i,
  input  logic halt_i,
  input  logic last_i,
  output logic load_o,
  output logic dec_o,
  output logic trip_o
);

  guard_state_e st_q;
  guard_state_e st_d;
  logic         watching;
  logic         counted;
  logic         expire;

  always_comb begin
    watching = (st_q == GS_WATCH);
    counted  = watching & unlock_i & tick_i;
    expire   = counted & last_i;
    load_o   = ~watching | ~unlock_i | expire;
    dec_o    = counted & ~last_i;
  end

  always_comb begin
    st_d = st_q;
    if (halt_i) begin
      st_d = GS_IDLE;
    end else begin
      case (st_q)
        GS_IDLE:  st_d = GS_WATCH;
        GS_WATCH: if (expire) st_d = GS_TRIP;
        GS_TRIP:  st_d = GS_TRIP;
        default:  st_d = GS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= GS_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign trip_o = (st_q == GS_TRIP);

  AST_HALT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> (st_q == GS_IDLE)); // R5
  AST_IDLE_ARMS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GS_IDLE) |=> (st_q != GS_TRIP)); // R6

endmodule

// File: rtl/stall_guard.sv
module stall_guard #(
  parameter int HOLD_TICKS  = 158,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic unlock_i,
  input  logic stop_i,
  input  logic guard_off_i,
  output logic trip_o
);

  localparam int CNT_W = $clog2(HOLD_TICKS + 1);

  logic rst_n_sync;
  logic halt;
  logic load;
  logic dec;
  logic last;

  assign halt = stop_i | guard_off_i;

  stall_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  stall_hold_cnt #(
    .HOLD_TICKS(HOLD_TICKS),
    .CNT_W     (CNT_W)
  ) u_hold_cnt (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .load_i(load),
    .dec_i (dec),
    .last_o(last)
  );

  stall_guard_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .tick_i  (tick_i),
    .unlock_i(unlock_i),
    .halt_i  (halt),
    .last_i  (last),
    .load_o  (load),
    .dec_o   (dec),
    .trip_o  (trip_o)
  );

  AST_TRIP_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(trip_o) |-> $past(tick_i && unlock_i)); // R2
  AST_TRIP_LATCHED: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (trip_o && !stop_i && !guard_off_i) |=> trip_o); // R4
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    stop_i |=> !trip_o); // R5
  AST_STRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_sync)
    guard_off_i |=> !trip_o); // R7
  AST_LOCKED_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!unlock_i && !trip_o) |=> !trip_o); // R8

endmodule

// File: tb/stall_guard_tb.sv
module stall_guard_tb;

  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic tick_i;
  logic unlock_i;
  logic stop_i;
  logic guard_off_i;
  logic trip_o;

  int    n_vec  = 0;
  int    n_bad  = 0;
  int    cycles = 0;
  bit    done   = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_state = 0;   // 0 idle, 1 watching, 2 tripped
  int m_left  = HOLD;
  int m_s1    = 0;
  int m_s2    = 0;

  always #4 clk = ~clk;   // 125 MHz

  stall_guard #(
    .HOLD_TICKS (HOLD),
    .SYNC_STAGES(2)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .unlock_i   (unlock_i),
    .stop_i     (stop_i),
    .guard_off_i(guard_off_i),
    .trip_o     (trip_o)
  );

  always @(posedge clk) begin
    int old2;
    old2 = m_s2;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_state = 0; m_left = HOLD;
    end else begin
      m_s2 = m_s1;
      m_s1 = 1;
      if (old2 == 0) begin
        m_state = 0; m_left = HOLD;
      end else if (stop_i || guard_off_i) begin
        m_state = 0; m_left = HOLD;
      end else if (m_state == 0) begin
        m_state = 1; m_left = HOLD;
      end else if (m_state == 1) begin
        if (!unlock_i) m_left = HOLD;
        else if (tick_i) begin
          if (m_left == 1) begin m_state = 2; m_left = HOLD; end
          else m_left = m_left - 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_vec++;
      if (trip_o !== (m_state == 2)) begin
        n_bad++;
        $display("FAIL %s: per-cycle trip_o=%0b expected %0b at %0t",
                 cur_req, trip_o, (m_state == 2), $time);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic exp);
    n_vec++;
    if (trip_o !== exp) begin
      n_bad++;
      $display("FAIL %s: trip_o=%0b expected %0b at %0t", req, trip_o, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; step(1);
      tick_i = 1'b0; step(2);
    end
  endtask

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; unlock_i = 1'b0;
    stop_i = 1'b0; guard_off_i = 1'b0;
    step(3);
    check("R1", 1'b0);
    rst_n = 1'b1;
    step(4);
    check("R1", 1'b0);

    // R2: exact expiry tick
    cur_req = "R2";
    unlock_i = 1'b1;
    ticks(HOLD - 1);
    check("R2", 1'b0);
    ticks(1);
    check("R2", 1'b1);

    // R4: latched through lock return and ticks
    cur_req = "R4";
    unlock_i = 1'b0;
    ticks(3);
    check("R4", 1'b1);
    unlock_i = 1'b1;
    ticks(2);
    check("R4", 1'b1);

    // R5: stop clears and suppresses counting
    cur_req = "R5";
    stop_i = 1'b1; step(1);
    check("R5", 1'b0);
    ticks(HOLD * 2);
    check("R5", 1'b0);

    // R6: tick in arming cycle ignored
    cur_req = "R6";
    stop_i = 1'b0; tick_i = 1'b1; step(1);
    tick_i = 1'b0; step(2);
    ticks(HOLD - 1);
    check("R6", 1'b0);
    ticks(1);
    check("R6", 1'b1);

    // R3: brief return to lock restarts count
    cur_req = "R3";
    stop_i = 1'b1; step(2);
    stop_i = 1'b0; step(2);
    ticks(HOLD - 1);
    unlock_i = 1'b0; step(1);
    unlock_i = 1'b1; step(1);
    ticks(HOLD - 1);
    check("R3", 1'b0);
    ticks(1);
    check("R3", 1'b1);

    // R8: locked ticks are not counted
    cur_req = "R8";
    stop_i = 1'b1; step(2);
    stop_i = 1'b0; unlock_i = 1'b0; step(2);
    ticks(HOLD * 2);
    check("R8", 1'b0);
    unlock_i = 1'b1;
    ticks(HOLD - 1);
    check("R8", 1'b0);
    ticks(1);
    check("R8", 1'b1);

    // R7: strap clears and disables
    cur_req = "R7";
    guard_off_i = 1'b1; step(1);
    check("R7", 1'b0);
    ticks(HOLD * 2);
    check("R7", 1'b0);
    guard_off_i = 1'b0; step(1);
    ticks(HOLD - 1);
    check("R7", 1'b0);
    ticks(1);
    check("R7", 1'b1);

    step(3);
    finish_run();
  end

endmodule